// File: doc/BRIEF.md
# Match-Driven Single-Edge PWM Timer

This block is an up-counting timer with a set of match registers that turns into a multi-channel PWM source. The counter moves forward by one on each cycle where the tick-enable input is high. Any match register can be chosen as the period register by setting its reset-on-match bit. On a tick where the count equals that register, the counter goes back to zero, so one period lasts period value + 1 ticks. Each channel in PWM mode drives a single-edge waveform. The output is LOW while the count is below the channel's match value and HIGH from the match until the wrap.

A simple write port loads the match values and three bit-vectors: reset-on-match enables, PWM-mode enables and external-match bits. A channel that is not in PWM mode drives its external-match bit to the output unchanged. The output register is updated on the same edge as the counter. A PWM output is therefore always in step with the count that is visible at the port.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset the count is 0, every output is LOW, and all enable and external-match bits are 0.
- R2: The count changes only on a clock edge where `tick` is 1. On such an edge it goes up by exactly one unless R3 applies.
- R3: On a tick where the count equals the match value of a channel whose reset-on-match bit is set (address 4, bit i for channel i), the count becomes 0.
- R4: Take a PWM channel with match M and period value P, where 0 < M <= P. The output is HIGH while the count is in the range M to P, which gives P-M+1 HIGH ticks in each P+1-tick period.
- R5: On the edge where the count wraps to 0, a PWM output with a nonzero match value goes LOW.
- R6: A PWM channel whose match value is above the period value stays LOW for the whole period.
- R7: A PWM channel whose match value equals the period value gives a pulse exactly one tick wide in each period.
- R8: A PWM channel with match value 0 stays LOW until the first wrap, goes HIGH on that wrap, and then stays HIGH.
- R9: If a channel's match value is rewritten to a value above the period while its output is HIGH, the output stays HIGH until the next wrap and is LOW from then on.
- R10: PWM-enable bit i (address 5) selects PWM mode for channel i. When the bit is clear, output i follows external-match bit i (address 6), and the PWM state has no effect on that output.
- R11: With `tick` low and no register write, no output changes.
- R12: Write addresses 0 to 3 load the match value of channels 0 to 3. A write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle prescaler tick; the counter moves only when this is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Write address: 0-3 match, 4 reset-on-match, 5 PWM enable, 6 external-match |
| wr_data | input | CW (32) | Write data |
| count | output | CW (32) | Current counter value |
| pwm_out | output | NCH (4) | Channel outputs |

## Verification
The bench measures the HIGH time of channels 0 to 2 over complete periods, with channel 3 used as the period register. It covers an ordinary duty, a match of zero, a match equal to the period and a match beyond the period. A design that cleared outputs on every wrap would lose the steady HIGH of the zero-match channel. A design that compared against the old count would shift every duty by one tick and stretch the equal-to-period pulse to two ticks. A further directed run rewrites a match value to a large number while the output is HIGH. It checks that the output neither drops at once nor sticks HIGH past the wrap. Held-off ticks and the external-match fallback are checked at the ports. These checks catch a counter that runs free and a PWM path that leaks into channels that are not in PWM mode.

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int CW  = 32,
  parameter int NCH = 4,
  parameter int AW  = $clog2(NCH + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [CW-1:0]  count,
  output logic [NCH-1:0] pwm_out
);
  localparam int ADDR_RST = NCH;
  localparam int ADDR_PWM = NCH + 1;
  localparam int ADDR_EXT = NCH + 2;

  logic [CW-1:0]  match_q [NCH];
  logic [NCH-1:0] rst_en_q, pwm_en_q, ext_q, out_q, hit;
  logic [CW-1:0]  cnt_q, cnt_nxt;
  logic           wrap;

  assign wrap    = |hit;
  assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
  assign count   = cnt_q;
  assign pwm_out = (pwm_en_q & out_q) | (~pwm_en_q & ext_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_en_q <= '0;
      pwm_en_q <= '0;
      ext_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_RST)) rst_en_q <= wr_data[NCH-1:0];
      if (wr_addr == AW'(ADDR_PWM)) pwm_en_q <= wr_data[NCH-1:0];
      if (wr_addr == AW'(ADDR_EXT)) ext_q    <= wr_data[NCH-1:0];
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = rst_en_q[i] && (cnt_q == match_q[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) match_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i)) match_q[i] <= wr_data;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_q[i] <= 1'b0;
      else if (tick) begin
        if (cnt_nxt == match_q[i]) out_q[i] <= 1'b1;
        else if (cnt_nxt == '0)    out_q[i] <= 1'b0;
      end

    p_cycle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wrap && pwm_en_q[i] && match_q[i] != '0 && !wr_en) |=> !pwm_out[i]);

    p_zero_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wrap && pwm_en_q[i] && match_q[i] == '0 && !wr_en) |=> pwm_out[i]);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> count == $past(count) + 1'b1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap) |=> count == '0);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(pwm_out));
endmodule

// File: tb/test_pwm_match_timer.sv
module test_pwm_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;

  typedef struct { int ch; int exp; string tag; } item_t;
  item_t exp_q[$];
  logic  mon_on = 1'b0;

  always #2.5 clk = ~clk;

  pwm_match_timer i_pwm_match_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .pwm_out(pwm_out)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    tick = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int hi_ticks(input int m, input int p);
    if (m > p) return 0;
    return p - m + 1;
  endfunction

  // driver: program a case and queue expected HIGH ticks per full period
  task automatic run_case(input int p, input int m0, input int m1, input int m2,
                          input int periods, input string tag);
    int m[3];
    m[0] = m0; m[1] = m1; m[2] = m2;
    do_reset();
    wr(0, m0); wr(1, m1); wr(2, m2); wr(3, p);
    wr(4, 8); wr(5, 7);
    for (int k = 0; k < periods; k++)
      for (int c = 0; c < 3; c++)
        exp_q.push_back('{c, hi_ticks(m[c], p), tag});
    @(negedge clk);
    mon_on = 1'b1; tick = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    tick = 1'b0; mon_on = 1'b0;
  endtask

  // monitor: count HIGH samples per full period, compare at each wrap
  initial begin
    int hi[3];
    logic [31:0] prevc;
    bit started;
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        started = 1'b0; prevc = count;
        for (int c = 0; c < 3; c++) hi[c] = 0;
      end else begin
        if (count == 0 && prevc != 0) begin
          if (started)
            for (int c = 0; c < 3; c++)
              if (exp_q.size() != 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(hi[it.ch], it.exp, it.tag);
              end
          started = 1'b1;
          for (int c = 0; c < 3; c++) hi[c] = 0;
        end
        for (int c = 0; c < 3; c++) hi[c] += int'(pwm_out[c]);
        prevc = count;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] snap;
    logic [31:0] csnap;
    do_reset();
    @(negedge clk);
    chk(int'(count), 0, "R1 count after reset");
    chk(int'(pwm_out), 0, "R1 outputs after reset");

    // R10: fallback outputs follow external bits
    wr(6, 4'b1010);
    chk(int'(pwm_out), 4'b1010, "R10 external bits drive outputs");
    wr(5, 4'b0011);
    chk(int'(pwm_out), 4'b1000, "R10 PWM channels ignore external bits");

    // R2: no ticks -> count held; one tick -> +1
    repeat (5) @(negedge clk);
    chk(int'(count), 0, "R2 count held without tick");
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk(int'(count), 1, "R2 single tick advances by one");
    repeat (3) @(negedge clk);
    chk(int'(count), 1, "R2 count held after tick");

    // scoreboard cases (R3 wrap drives period detection; R12 loads match values)
    run_case(9, 3, 0, 9, 3, "R4/R8/R7/R12 P=9 m=3,0,9");
    run_case(5, 6, 1, 5, 3, "R6/R4/R7/R3 P=5 m=6,1,5");
    run_case(12, 12, 7, 40, 2, "R7/R4/R6 P=12 m=12,7,40");

    // R11: outputs frozen while tick low
    run_case(6, 2, 0, 4, 1, "R4/R8 P=6 m=2,0,4");
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    snap = pwm_out; csnap = count;
    repeat (4) @(negedge clk);
    chk(int'(pwm_out), int'(snap), "R11 outputs stable without tick");
    chk(int'(count), int'(csnap), "R2 count stable without tick");

    // R9 / R5 / R6: match raised while HIGH
    do_reset();
    wr(0, 2); wr(3, 7); wr(4, 8); wr(5, 1);
    @(negedge clk);
    tick = 1'b1;
    while (count != 4) @(negedge clk);
    chk(int'(pwm_out[0]), 1, "R4 high after match reached");
    wr(0, 100);
    while (count != 7) @(negedge clk);
    chk(int'(pwm_out[0]), 1, "R9 stays high until wrap");
    @(negedge clk);
    chk(int'(count), 0, "R3 counter wraps after period value");
    chk(int'(pwm_out[0]), 0, "R9/R5 cleared at wrap");
    begin
      int hs = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        hs += int'(pwm_out[0]);
      end
      chk(hs, 0, "R6 large match keeps output low");
    end
    tick = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule